// File: doc/BRIEF.md
# Infrared Command Store and Repeat Sequencer

This block keeps an infrared remote-control command as a list of 16-bit words in a code store. An optional alternative repeat command can be held in a second, smaller repeat store. When transmission is started, the block presents the words one bit at a time to a downstream symbol modulator over a valid/ready handshake. Each bit is held until the modulator accepts it. The modulator that turns bits into marks and spaces on a carrier sits outside this block.

A repeat timer counts carrier periods, supplied as a one-cycle tick input, from the moment each command begins. When the timer has expired and the current command has finished, the block sends the command again. A mode input chooses whether the repeat comes from the code store or from the repeat store. The stores are read by rewinding an index rather than by popping, so a command can be sent any number of times. Software sees word counts for both stores, a busy flag, and a completion interrupt that is cleared by an acknowledge pulse, which corresponds to reading the interrupt status.

Top module: `ir_cmd_sequencer`

## Requirements
- R1: After reset, `bit_valid`, `busy` and `irq` are 0 and both word counts are 0.
- R2: Each write appends one word to its store, and the store's count gives the number of words held. The code store holds up to 32 words, so its count is 0..32 in 6 bits. The repeat store holds up to 8 words, so its count is 0..8 in 4 bits. A write to a full store changes nothing.
- R3: A rising edge on `start` while the code store is non-empty begins a command. Every held word is sent in write order, with bit 15 of each word first. Exactly one bit is accepted in each cycle in which `bit_valid` and `bit_ready` are both 1, and `bit_data` holds steady while the bit waits.
- R4: `busy` is 1 exactly while `bit_valid` is 1, that is, while a command is being sent.
- R5: When the last bit of a command is accepted and `irq_en` is 1, `irq` rises in the next cycle. It stays high until an `irq_ack` pulse clears it. With `irq_en` at 0, a completed command leaves `irq` low.
- R6: With `rep_time` at 0, the command is sent only once. The block then goes idle with the store contents and counts kept.
- R7: With `rep_time` = N > 0, the timer counts `carrier_tick` pulses from the start of each command. The next command starts in the cycle after both of these hold: N ticks have been counted and the previous command has finished.
- R8: When a repeat is due and `rep_sel` is 0, the code store is sent again. When `rep_sel` is 1, the repeat store is sent. If the chosen store is empty, the block goes idle.
- R9: A falling edge on `start` stops any transmission at once and empties the code store. The repeat store is left unchanged.
- R10: A `code_flush` pulse empties only the code store, and a `rep_flush` pulse empties only the repeat store.
- R11: While `en` is 0, the block is held in its reset state: nothing is sent, `irq` is 0, both stores are emptied, and writes are ignored.
- R12: A rising edge on `start` while the code store is empty sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low holds the block in reset |
| start | input | 1 | Transmit request level; a rising edge starts, a falling edge aborts and empties the code store |
| rep_sel | input | 1 | Repeat source: 0 = code store, 1 = repeat store |
| irq_en | input | 1 | Completion interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse (status read) |
| code_wr | input | 1 | Code store write strobe |
| code_wdata | input | 16 | Code store write word |
| rep_wr | input | 1 | Repeat store write strobe |
| rep_wdata | input | 16 | Repeat store write word |
| code_flush | input | 1 | Empty the code store (pulse) |
| rep_flush | input | 1 | Empty the repeat store (pulse) |
| rep_time | input | 16 | Repeat period in carrier ticks; 0 disables repeating |
| carrier_tick | input | 1 | One pulse per carrier period |
| bit_ready | input | 1 | Modulator accepts the presented bit |
| bit_valid | output | 1 | A bit is presented |
| bit_data | output | 1 | The presented bit |
| busy | output | 1 | A command is being sent |
| code_count | output | 6 | Words held in the code store |
| rep_count | output | 4 | Words held in the repeat store |
| irq | output | 1 | Completion interrupt |

## Verification
The bench stalls the handshake in irregular patterns. A sequencer that moved on without a ready bit, or that changed the presented bit while stalled, would corrupt the captured word. Repeat spacing is measured in both regimes: a period longer than the command, where the restart must come exactly N+1 cycles after the previous start, and a period shorter than the command, where a design that cut the command short or repeated too early would show up. The bench also covers an empty repeat store, a full store, and an abort partway through a word. A design that kept looping, accepted overflow writes, or flushed the wrong store would leave a wrong count or a stray `bit_valid`.

// File: rtl/ir_seq_pkg.sv
package ir_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SEND = 2'd1,
      SEQ_GAP  = 2'd2
   } seq_state_t;

   typedef enum logic {
      SRC_CODE = 1'b0,
      SRC_REP  = 1'b1
   } src_t;
endpackage

// File: rtl/ir_word_store.sv
module ir_word_store #(
   parameter int WORD_W  = 16,
   parameter int DEPTH   = 32,
   parameter int IDXIN_W = 6,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [IDXIN_W-1:0] rd_idx,
   output logic [WORD_W-1:0]  rdata,
   output logic [CNT_W-1:0]   count
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic              full;

   if (IDXIN_W < IDX_W) begin : g_bad_idx
      $error("ir_word_store: read index narrower than store address");
   end

   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (wr && !clr && !full)
         mem[count[IDX_W-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (wr && !full)
         count <= count + 1'b1;
   end

   // rewinding read: contents stay for repeats
   assign rdata = (int'(rd_idx) < DEPTH) ? mem[rd_idx[IDX_W-1:0]] : '0;

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r2_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);
endmodule

// File: rtl/ir_repeat_timer.sv
module ir_repeat_timer #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              restart,
   input  logic              run,
   input  logic              tick,
   input  logic [TIME_W-1:0] limit,
   output logic              due
);
   logic [TIME_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         due <= 1'b0;
      end else if (clr || restart) begin
         cnt <= '0;
         due <= 1'b0;
      end else if (run && tick && !due && (limit != '0)) begin
         cnt <= cnt + 1'b1;
         if (cnt == TIME_W'(limit - 1'b1))
            due <= 1'b1;
      end
   end

   a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !due);

   a_r7_zero_never_due: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && !due) |=> !due);
endmodule

// File: rtl/ir_cmd_sequencer.sv
module ir_cmd_sequencer
   import ir_seq_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int CODE_DEPTH = 32,
   parameter int REP_DEPTH  = 8,
   parameter int TIME_W     = 16,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              en,
   input  logic                              start,
   input  logic                              rep_sel,
   input  logic                              irq_en,
   input  logic                              irq_ack,
   input  logic                              code_wr,
   input  logic [WORD_W-1:0]                 code_wdata,
   input  logic                              rep_wr,
   input  logic [WORD_W-1:0]                 rep_wdata,
   input  logic                              code_flush,
   input  logic                              rep_flush,
   input  logic [TIME_W-1:0]                 rep_time,
   input  logic                              carrier_tick,
   input  logic                              bit_ready,
   output logic                              bit_valid,
   output logic                              bit_data,
   output logic                              busy,
   output logic [$clog2(CODE_DEPTH+1)-1:0]   code_count,
   output logic [$clog2(REP_DEPTH+1)-1:0]    rep_count,
   output logic                              irq
);
   localparam int CODE_CW = $clog2(CODE_DEPTH + 1);
   localparam int REP_CW  = $clog2(REP_DEPTH + 1);
   localparam int IDX_W   = (CODE_CW > REP_CW) ? CODE_CW : REP_CW;
   localparam int BIT_W   = $clog2(WORD_W);

   if (WORD_W < 2 || CODE_DEPTH < 1 || REP_DEPTH < 1 || TIME_W < 1) begin : g_bad_cfg
      $error("ir_cmd_sequencer: illegal parameter set");
   end

   seq_state_t        state_q, state_d;
   src_t              src_q, src_d;
   logic [IDX_W-1:0]  word_q, word_d;
   logic [BIT_W-1:0]  bit_q, bit_d;
   logic              start_q, irq_q;
   logic              restart, done_evt, due;
   logic              start_rise, start_fall;
   logic [WORD_W-1:0] code_rdata, rep_rdata, cur_word;
   logic [IDX_W-1:0]  sel_cnt, next_cnt;
   logic              word_last, bit_last, sel_bit;

   assign start_rise = en && start && !start_q;
   assign start_fall = en && !start && start_q;

   ir_word_store #(.WORD_W(WORD_W), .DEPTH(CODE_DEPTH), .IDXIN_W(IDX_W)) u_code (
      .clk(clk), .rst_n(rst_n), .clr(!en || code_flush || start_fall),
      .wr(code_wr), .wdata(code_wdata), .rd_idx(word_q),
      .rdata(code_rdata), .count(code_count));

   ir_word_store #(.WORD_W(WORD_W), .DEPTH(REP_DEPTH), .IDXIN_W(IDX_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .clr(!en || rep_flush),
      .wr(rep_wr), .wdata(rep_wdata), .rd_idx(word_q),
      .rdata(rep_rdata), .count(rep_count));

   ir_repeat_timer #(.TIME_W(TIME_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(!en), .restart(restart),
      .run(state_q != SEQ_IDLE), .tick(carrier_tick),
      .limit(rep_time), .due(due));

   assign sel_cnt   = (src_q == SRC_REP) ? IDX_W'(rep_count) : IDX_W'(code_count);
   assign next_cnt  = rep_sel ? IDX_W'(rep_count) : IDX_W'(code_count);
   assign word_last = (IDX_W'(word_q + 1'b1) >= sel_cnt);
   assign bit_last  = (bit_q == BIT_W'(WORD_W - 1));
   assign cur_word  = (src_q == SRC_REP) ? rep_rdata : code_rdata;

   if (MSB_FIRST) begin : g_msb
      assign sel_bit = cur_word[BIT_W'(WORD_W - 1) - bit_q];
   end else begin : g_lsb
      assign sel_bit = cur_word[bit_q];
   end

   always_comb begin
      state_d  = state_q;
      src_d    = src_q;
      word_d   = word_q;
      bit_d    = bit_q;
      restart  = 1'b0;
      done_evt = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (start_rise && code_count != '0) begin
               state_d = SEQ_SEND;
               src_d   = SRC_CODE;
               word_d  = '0;
               bit_d   = '0;
               restart = 1'b1;
            end
         end
         SEQ_SEND: begin
            if (bit_ready) begin
               if (bit_last) begin
                  bit_d = '0;
                  if (word_last) begin
                     done_evt = 1'b1;
                     state_d  = (rep_time != '0) ? SEQ_GAP : SEQ_IDLE;
                  end else begin
                     word_d = word_q + 1'b1;
                  end
               end else begin
                  bit_d = bit_q + 1'b1;
               end
            end
         end
         SEQ_GAP: begin
            if (rep_time == '0) begin
               state_d = SEQ_IDLE;
            end else if (due) begin
               if (next_cnt != '0) begin
                  state_d = SEQ_SEND;
                  src_d   = rep_sel ? SRC_REP : SRC_CODE;
                  word_d  = '0;
                  bit_d   = '0;
                  restart = 1'b1;
               end else begin
                  state_d = SEQ_IDLE;
               end
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
      if (start_fall) begin
         state_d  = SEQ_IDLE;
         restart  = 1'b0;
         done_evt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         src_q   <= SRC_CODE;
         word_q  <= '0;
         bit_q   <= '0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else if (!en) begin
         state_q <= SEQ_IDLE;
         src_q   <= SRC_CODE;
         word_q  <= '0;
         bit_q   <= '0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         src_q   <= src_d;
         word_q  <= word_d;
         bit_q   <= bit_d;
         start_q <= start;
         if (done_evt && irq_en)
            irq_q <= 1'b1;
         else if (irq_ack)
            irq_q <= 1'b0;
      end
   end

   assign bit_valid = (state_q == SEQ_SEND);
   assign bit_data  = bit_valid ? sel_bit : 1'b0;
   assign busy      = (state_q == SEQ_SEND);
   assign irq       = irq_q;

   a_r3_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !bit_ready && !code_wr && !rep_wr) |=> (!bit_valid || $stable(bit_data)));

   a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack && en) |=> irq);

   a_r9_fall_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (en && start_q && !start) |=> (!bit_valid && code_count == '0));

   a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!bit_valid && !irq && code_count == '0 && rep_count == '0));

   a_r12_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE && code_count == '0) |=> !bit_valid);
endmodule

// File: tb/ir_cmd_sequencer_test.sv
module ir_cmd_sequencer_test;
   logic clk = 1'b0;
   logic rst_n, en, start, rep_sel, irq_en, irq_ack;
   logic code_wr, rep_wr, code_flush, rep_flush, carrier_tick, bit_ready;
   logic [15:0] code_wdata, rep_wdata, rep_time;
   logic bit_valid, bit_data, busy, irq;
   logic [5:0] code_count;
   logic [3:0] rep_count;

   int n_checks = 0;
   int n_errs   = 0;
   int busy_mis = 0;
   int cyc_cnt  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   ir_cmd_sequencer uut (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .rep_sel(rep_sel),
      .irq_en(irq_en), .irq_ack(irq_ack), .code_wr(code_wr), .code_wdata(code_wdata),
      .rep_wr(rep_wr), .rep_wdata(rep_wdata), .code_flush(code_flush),
      .rep_flush(rep_flush), .rep_time(rep_time), .carrier_tick(carrier_tick),
      .bit_ready(bit_ready), .bit_valid(bit_valid), .bit_data(bit_data), .busy(busy),
      .code_count(code_count), .rep_count(rep_count), .irq(irq));

   // word, stall mask (bit k low = ready in cycle k mod 16)
   localparam logic [31:0] VEC [6] = '{
      {16'hA5C3, 16'h0000}, {16'h8001, 16'h00F0}, {16'h7FFE, 16'h5555},
      {16'h0000, 16'h0F0F}, {16'hFFFF, 16'h8421}, {16'h1234, 16'h3003}};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_code(input logic [15:0] w);
      code_wr = 1'b1; code_wdata = w;
      @(negedge clk);
      code_wr = 1'b0;
   endtask

   task automatic wr_rep(input logic [15:0] w);
      rep_wr = 1'b1; rep_wdata = w;
      @(negedge clk);
      rep_wr = 1'b0;
   endtask

   task automatic collect(input int nbits, input logic [15:0] stall, output logic [63:0] got);
      int k = 0;
      int c = 0;
      got = '0;
      while (k < nbits && c < 5000) begin
         bit_ready = !stall[c % 16];
         if (busy !== bit_valid) busy_mis++;
         if (bit_valid && bit_ready) begin
            got = {got[62:0], bit_data};
            k++;
         end
         @(negedge clk);
         c++;
      end
      bit_ready = 1'b0;
   endtask

   task automatic wait_valid(input logic lvl, output int t);
      int c = 0;
      while (bit_valid !== lvl && c < 3000) begin
         @(negedge clk);
         c++;
      end
      t = (c < 3000) ? cyc_cnt : -1;
   endtask

   task automatic quiet(input int n, output int seen);
      seen = 0;
      for (int i = 0; i < n; i++) begin
         if (bit_valid || busy) seen++;
         @(negedge clk);
      end
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] got;
      int t0, t1, seen;
      rst_n = 0; en = 0; start = 0; rep_sel = 0; irq_en = 0; irq_ack = 0;
      code_wr = 0; rep_wr = 0; code_flush = 0; rep_flush = 0; carrier_tick = 1;
      bit_ready = 0; code_wdata = '0; rep_wdata = '0; rep_time = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      en = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idle", {bit_valid, busy, irq}, 3'b000);
      chk("R1 counts", {code_count, rep_count}, 10'd0);

      // table walk: R3 serialization under stalls, R4 busy, R6/R9 counts
      foreach (VEC[i]) begin
         wr_code(VEC[i][31:16]);
         start = 1'b1;
         busy_mis = 0;
         collect(16, VEC[i][15:0], got);
         chk("R3 word", got[15:0], {48'd0, VEC[i][31:16]});
         chk("R4 busy", busy_mis, 0);
         chk("R6 count kept", code_count, 6'd1);
         start = 1'b0;
         @(negedge clk);
         chk("R9 flushed", code_count, 6'd0);
      end

      // R3 multi-word order, R5 interrupt raise and ack, R6 single shot
      irq_en = 1'b1;
      wr_code(16'hC001); wr_code(16'h5A5A); wr_code(16'h0FF0);
      start = 1'b1;
      collect(48, 16'h0000, got);
      chk("R3 three words", got[47:0], 48'hC0015A5A0FF0);
      chk("R5 irq raised", irq, 1'b1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk("R5 irq cleared", irq, 1'b0);
      quiet(20, seen);
      chk("R6 no resend", seen, 0);
      chk("R6 count kept", code_count, 6'd3);
      start = 1'b0;
      @(negedge clk);

      // R5 masked
      irq_en = 1'b0;
      wr_code(16'h1111);
      start = 1'b1;
      collect(16, 16'h0000, got);
      @(negedge clk);
      chk("R5 masked", irq, 1'b0);
      start = 1'b0;
      @(negedge clk);

      // R7 long repeat period: restart N+1 cycles after previous start
      bit_ready = 1'b1;
      wr_code(16'hBEEF);
      rep_time = 16'd40;
      start = 1'b1;
      bit_ready = 1'b1;
      wait_valid(1'b1, t0);
      wait_valid(1'b0, t1);
      wait_valid(1'b1, t1);
      chk("R7 long period", t1 - t0, 41);
      start = 1'b0;
      @(negedge clk);
      // R7 short period: repeat right after the 16-bit command
      wr_code(16'hBEEF);
      rep_time = 16'd5;
      start = 1'b1;
      wait_valid(1'b1, t0);
      wait_valid(1'b0, t1);
      wait_valid(1'b1, t1);
      chk("R7 short period", t1 - t0, 17);
      start = 1'b0;
      bit_ready = 1'b0;
      @(negedge clk);

      // R8 repeat source = repeat store
      wr_code(16'hAAAA);
      wr_rep(16'h3C3C);
      rep_time = 16'd20;
      rep_sel = 1'b1;
      start = 1'b1;
      collect(48, 16'h0000, got);
      chk("R8 repeat store", got[47:0], 48'hAAAA3C3C3C3C);
      start = 1'b0;
      @(negedge clk);
      chk("R9 repeat kept", rep_count, 4'd1);

      // R8 empty chosen store -> idle; R10 repeat flush
      rep_flush = 1'b1;
      @(negedge clk);
      rep_flush = 1'b0;
      chk("R10 rep flush", rep_count, 4'd0);
      wr_code(16'h00FF);
      rep_time = 16'd5;
      start = 1'b1;
      collect(16, 16'h0000, got);
      quiet(15, seen);
      chk("R8 empty source idle", seen, 0);
      start = 1'b0;
      rep_sel = 1'b0;
      rep_time = 16'd0;
      @(negedge clk);

      // R9 abort mid word
      wr_code(16'h1357); wr_code(16'h2468);
      wr_rep(16'h9999);
      start = 1'b1;
      collect(5, 16'h0000, got);
      start = 1'b0;
      @(negedge clk);
      chk("R9 abort stops", bit_valid, 1'b0);
      chk("R9 abort counts", {code_count, rep_count}, {6'd0, 4'd1});

      // R2 full stores; R10 code flush alone
      for (int i = 0; i < 33; i++) wr_code(16'(i));
      for (int i = 0; i < 9; i++) wr_rep(16'(i));
      chk("R2 code full", code_count, 6'd32);
      chk("R2 rep full", rep_count, 4'd8);
      code_flush = 1'b1;
      @(negedge clk);
      code_flush = 1'b0;
      chk("R10 code flush", {code_count, rep_count}, {6'd0, 4'd8});
      rep_flush = 1'b1;
      @(negedge clk);
      rep_flush = 1'b0;

      // R12 start with empty code store
      start = 1'b1;
      quiet(20, seen);
      chk("R12 empty start", seen, 0);
      start = 1'b0;
      @(negedge clk);

      // R11 disable mid-command
      irq_en = 1'b1;
      wr_code(16'hF00D);
      wr_rep(16'h0101);
      start = 1'b1;
      collect(5, 16'h0000, got);
      en = 1'b0;
      @(negedge clk);
      chk("R11 stopped", {bit_valid, busy, irq}, 3'b000);
      chk("R11 emptied", {code_count, rep_count}, 10'd0);
      start = 1'b0;
      wr_code(16'h7777);
      en = 1'b1;
      @(negedge clk);
      chk("R11 write ignored", code_count, 6'd0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule